// File: doc/BRIEF.md
# Raster Sync and Display-Window Timing Generator

This block keeps track of the horizontal pixel position and the vertical line position of a video raster for an on-screen text overlay. From those two counters it produces the timing marks that the rest of the overlay pipeline needs. One pulse marks the first pixel of the character area on each line. Another marks the first line of that area. A window marks the line's black-level clamp interval.

The block runs in one of two ways. As a sync source, it times the raster itself and drives horizontal and vertical sync on its two pins. Optionally, the vertical pin carries a composite sync with equalizing pulses instead. As a sync follower, it resets its counters from external syncs. These come either on two separate pins or as a single sandcastle pulse train on the horizontal pin, split into line and field events by pulse width.

Configuration goes through a plain write port and a combinational read port. No data stream passes through the block, so it has no valid/ready interface. The sync inputs are expected to be already synchronous to `clk`.

Top module: `raster_sync_gen`

## Requirements
- R1: After reset, the read port returns these values. Control (address 0) is 0, which selects follower mode. Vertical delay (address 1) is 32 and horizontal delay (address 2) is 72. Clamp begin (address 3) is 2 and clamp end (address 4) is 10. H period (address 5) is 1024 clocks and total lines (address 6) is 625. Address 7 reads 0.
- R2: A write stores the low bits of `wr_data` at `wr_addr`, keeping only the field width: 10 bits at addresses 1 and 6, 12 bits at addresses 2 and 5, 8 bits at addresses 3 and 4. The control word uses bit 0 for source mode, bit 1 for sandcastle select and bit 2 for composite select. All other read bits are 0.
- R3: In follower mode with separate syncs, a clock where `h_in` rises sets the pixel count to 0 and advances the line count, which saturates at its maximum. A clock where `v_in` rises sets both counts to 0. Otherwise the pixel count advances by one and saturates at its maximum.
- R4: In follower mode with sandcastle select, `v_in` is ignored. A falling edge of `h_in` after a high time of at least 16 clocks is a field event, handled like a `v_in` rise in R3. A shorter high time gives a line event, handled like an `h_in` rise in R3.
- R5: In source mode the pixel count runs from 0 to period−1 and then returns to 0 while the line count advances. The line count wraps to 0 after total lines−1. In follower mode the period and total-line registers have no effect.
- R6: In source mode `sync_oe` is 1 and `h_out` is high for pixel counts 0 to 7. `v_out` is high for line counts 0 to 2 when composite is off. In follower mode `h_out`, `v_out` and `sync_oe` are 0.
- R7: In source mode with composite on, `v_out` behaves as follows. It is high for the whole of lines 0 to 2. On lines 3 and 4 and on the last two lines of the frame, it is high for pixel counts 0 to 3 and for the 4 pixels starting at period/2. On all other lines it follows the horizontal sync of R6.
- R8: Switching from follower to source mode keeps the current counts. The pixel count continues from its present value and only wraps once it reaches period−1.
- R9: `disp_hstart` is high exactly when the pixel count equals the horizontal delay. `disp_vstart` is high exactly when the pixel count is 0 and the line count equals the vertical delay.
- R10: With clamp begin not above clamp end, `clamp_win` is high for pixel counts from 4×begin up to but not including 4×end.
- R11: With clamp begin above clamp end, the window wraps. `clamp_win` is high for pixel counts at or above 4×begin and for pixel counts below 4×end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| h_in | input | 1 | External horizontal sync or sandcastle input |
| v_in | input | 1 | External vertical sync input |
| h_out | output | 1 | Generated horizontal sync (source mode) |
| v_out | output | 1 | Generated vertical or composite sync (source mode) |
| sync_oe | output | 1 | Sync pin drive enable, high in source mode |
| disp_hstart | output | 1 | First pixel of the character area |
| disp_vstart | output | 1 | First line of the character area |
| clamp_win | output | 1 | Horizontal clamp window |

## Verification
The embedded assertions watch four behaviours on every cycle. The source-mode pixel count either steps by one or returns to zero. A follower field event clears both counts on the next clock. Sandcastle decoding never yields a line and a field event together. The sync pins stay low in follower mode. Two further checks cover the horizontal-start pulse lasting one cycle and the wrapped clamp window covering pixel zero. The remaining behaviours depend on whole sequences, and only the bench scenarios can show them. These are the exact sync and equalizing pulse placement over a frame, the counts carrying across a mode switch, the width threshold between sandcastle line and field pulses, and register masking.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int RSG_HW = 12;
  localparam int RSG_VW = 10;
  localparam int RSG_CW = 8;
  localparam int RSG_DW = 16;
  localparam int RSG_AW = 3;

  typedef enum logic [RSG_AW-1:0] {
    A_CTRL  = 3'd0,
    A_VDLY  = 3'd1,
    A_HDLY  = 3'd2,
    A_CLB   = 3'd3,
    A_CLE   = 3'd4,
    A_HPER  = 3'd5,
    A_LINES = 3'd6,
    A_NONE  = 3'd7
  } rsg_addr_e;

  typedef struct packed {
    logic              master;
    logic              sc_sel;
    logic              comp;
    logic [RSG_VW-1:0] vdelay;
    logic [RSG_HW-1:0] hdelay;
    logic [RSG_CW-1:0] clamp_b;
    logic [RSG_CW-1:0] clamp_e;
    logic [RSG_HW-1:0] hper;
    logic [RSG_VW-1:0] lines;
  } rsg_cfg_t;
endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
  import rsg_pkg::*;
#(
  parameter int VDLY_RST  = 32,
  parameter int HDLY_RST  = 72,
  parameter int CLB_RST   = 2,
  parameter int CLE_RST   = 10,
  parameter int HPER_RST  = 1024,
  parameter int LINES_RST = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSG_AW-1:0] wr_addr,
  input  logic [RSG_DW-1:0] wr_data,
  input  logic [RSG_AW-1:0] rd_addr,
  output logic [RSG_DW-1:0] rd_data,
  output rsg_cfg_t          cfg
);
  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[RSG_DW-1:RSG_HW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.master  <= 1'b0;
      cfg.sc_sel  <= 1'b0;
      cfg.comp    <= 1'b0;
      cfg.vdelay  <= RSG_VW'(VDLY_RST);
      cfg.hdelay  <= RSG_HW'(HDLY_RST);
      cfg.clamp_b <= RSG_CW'(CLB_RST);
      cfg.clamp_e <= RSG_CW'(CLE_RST);
      cfg.hper    <= RSG_HW'(HPER_RST);
      cfg.lines   <= RSG_VW'(LINES_RST);
    end else if (wr_en) begin
      case (rsg_addr_e'(wr_addr))
        A_CTRL: begin
          cfg.master <= wr_data[0];
          cfg.sc_sel <= wr_data[1];
          cfg.comp   <= wr_data[2];
        end
        A_VDLY:  cfg.vdelay  <= wr_data[RSG_VW-1:0];
        A_HDLY:  cfg.hdelay  <= wr_data[RSG_HW-1:0];
        A_CLB:   cfg.clamp_b <= wr_data[RSG_CW-1:0];
        A_CLE:   cfg.clamp_e <= wr_data[RSG_CW-1:0];
        A_HPER:  cfg.hper    <= wr_data[RSG_HW-1:0];
        A_LINES: cfg.lines   <= wr_data[RSG_VW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rsg_addr_e'(rd_addr))
      A_CTRL:  rd_data = RSG_DW'({cfg.comp, cfg.sc_sel, cfg.master});
      A_VDLY:  rd_data = RSG_DW'(cfg.vdelay);
      A_HDLY:  rd_data = RSG_DW'(cfg.hdelay);
      A_CLB:   rd_data = RSG_DW'(cfg.clamp_b);
      A_CLE:   rd_data = RSG_DW'(cfg.clamp_e);
      A_HPER:  rd_data = RSG_DW'(cfg.hper);
      A_LINES: rd_data = RSG_DW'(cfg.lines);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rsg_sync_in.sv
module rsg_sync_in #(
  parameter int SC_THR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic h_in,
  input  logic v_in,
  input  logic sc_sel,
  output logic h_ev,
  output logic v_ev
);
  localparam int SCW = $clog2(SC_THR + 1);
  localparam logic [SCW-1:0] THR = SCW'(SC_THR);

  logic           h_q, v_q;
  logic [SCW-1:0] sc_w;
  logic           h_fall, sc_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q  <= 1'b0;
      v_q  <= 1'b0;
      sc_w <= '0;
    end else begin
      h_q <= h_in;
      v_q <= v_in;
      if (!h_in)          sc_w <= '0;
      else if (sc_w < THR) sc_w <= sc_w + SCW'(1);
    end
  end

  assign h_fall  = h_q & ~h_in;
  assign sc_long = (sc_w >= THR);

  always_comb begin
    if (sc_sel) begin
      v_ev = h_fall & sc_long;
      h_ev = h_fall & ~sc_long;
    end else begin
      h_ev = h_in & ~h_q;
      v_ev = v_in & ~v_q;
    end
  end

  // R4: a sandcastle edge is either a line or a field event, never both
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    sc_sel |-> $onehot0({h_ev, v_ev}));
endmodule

// File: rtl/rsg_counters.sv
module rsg_counters
  import rsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic [RSG_HW-1:0] hper,
  input  logic [RSG_VW-1:0] lines,
  input  logic              h_ev,
  input  logic              v_ev,
  output logic [RSG_HW-1:0] hcnt,
  output logic [RSG_VW-1:0] vcnt
);
  localparam logic [RSG_HW-1:0] HMAX = '1;
  localparam logic [RSG_VW-1:0] VMAX = '1;

  logic [RSG_HW-1:0] hlim;
  logic [RSG_VW-1:0] vlim;

  assign hlim = (hper == '0) ? '0 : hper - RSG_HW'(1);
  assign vlim = (lines == '0) ? '0 : lines - RSG_VW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (master) begin
      if (hcnt >= hlim) begin
        hcnt <= '0;
        vcnt <= (vcnt >= vlim) ? '0 : vcnt + RSG_VW'(1);
      end else begin
        hcnt <= hcnt + RSG_HW'(1);
      end
    end else if (v_ev) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_ev) begin
      hcnt <= '0;
      if (vcnt != VMAX) vcnt <= vcnt + RSG_VW'(1);
    end else if (hcnt != HMAX) begin
      hcnt <= hcnt + RSG_HW'(1);
    end
  end

  // R5/R8: in source mode the pixel count only steps by one or restarts
  a_r5_master_step: assert property (@(posedge clk) disable iff (!rst_n)
    master |=> (hcnt == '0 || hcnt == $past(hcnt) + RSG_HW'(1)));

  // R3: a follower field event clears both counts
  a_r3_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && v_ev) |=> (hcnt == '0 && vcnt == '0));
endmodule

// File: rtl/rsg_decode.sv
module rsg_decode
  import rsg_pkg::*;
#(
  parameter int CLAMP_DIV = 4,
  parameter int HS_W      = 8,
  parameter int VS_LINES  = 3,
  parameter int EQ_LINES  = 2,
  parameter int EQ_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              comp,
  input  logic [RSG_HW-1:0] hcnt,
  input  logic [RSG_VW-1:0] vcnt,
  input  logic [RSG_HW-1:0] hper,
  input  logic [RSG_VW-1:0] lines,
  input  logic [RSG_HW-1:0] hdelay,
  input  logic [RSG_VW-1:0] vdelay,
  input  logic [RSG_CW-1:0] clamp_b,
  input  logic [RSG_CW-1:0] clamp_e,
  output logic              h_out,
  output logic              v_out,
  output logic              sync_oe,
  output logic              disp_hstart,
  output logic              disp_vstart,
  output logic              clamp_win
);
  localparam int CPW = RSG_HW + RSG_CW;
  localparam logic [RSG_HW-1:0] HSW  = RSG_HW'(HS_W);
  localparam logic [RSG_HW-1:0] EQW  = RSG_HW'(EQ_W);
  localparam logic [RSG_VW-1:0] VSL  = RSG_VW'(VS_LINES);
  localparam logic [RSG_VW:0]   EQL  = (RSG_VW+1)'(EQ_LINES);
  localparam logic [RSG_VW:0]   VSEQ = (RSG_VW+1)'(VS_LINES + EQ_LINES);

  logic            hs, vs_line, eq_line, eq_pulse, comp_val;
  logic [RSG_HW-1:0] half;
  logic [RSG_HW:0]   half_end;
  logic [CPW-1:0]    cl_b, cl_e, hc_w;

  assign hs       = (hcnt < HSW);
  assign vs_line  = (vcnt < VSL);
  assign half     = hper >> 1;
  assign half_end = {1'b0, half} + {1'b0, EQW};
  assign eq_pulse = (hcnt < EQW) ||
                    (hcnt >= half && {1'b0, hcnt} < half_end);

  generate
    if (EQ_LINES == 0) begin : g_no_eq
      assign eq_line = 1'b0;
    end else begin : g_eq
      assign eq_line = !vs_line &&
                       (({1'b0, vcnt} < VSEQ) ||
                        ({1'b0, vcnt} + EQL >= {1'b0, lines}));
    end
  endgenerate

  always_comb begin
    if (vs_line)      comp_val = 1'b1;
    else if (eq_line) comp_val = eq_pulse;
    else              comp_val = hs;
  end

  assign sync_oe = master;
  assign h_out   = master & hs;
  assign v_out   = master & (comp ? comp_val : vs_line);

  assign disp_hstart = (hcnt == hdelay);
  assign disp_vstart = (hcnt == '0) && (vcnt == vdelay);

  assign cl_b = CPW'(clamp_b) * CPW'(CLAMP_DIV);
  assign cl_e = CPW'(clamp_e) * CPW'(CLAMP_DIV);
  assign hc_w = CPW'(hcnt);

  always_comb begin
    if (clamp_b <= clamp_e) clamp_win = (hc_w >= cl_b) && (hc_w < cl_e);
    else                    clamp_win = (hc_w >= cl_b) || (hc_w < cl_e);
  end

  // R6: follower mode keeps both sync pins low
  a_r6_follower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe |-> (!h_out && !v_out));

  // R9: the horizontal start mark lasts one cycle while its delay is steady
  a_r9_hstart_single: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_hstart && hdelay != '0 && hdelay != '1) |=>
      (!disp_hstart || hdelay != $past(hdelay)));

  // R11: a wrapped window covers the sync start
  a_r11_wrap_covers_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_b > clamp_e && clamp_e != '0 && hcnt == '0) |-> clamp_win);
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int VDLY_RST  = 32,
  parameter int HDLY_RST  = 72,
  parameter int CLB_RST   = 2,
  parameter int CLE_RST   = 10,
  parameter int HPER_RST  = 1024,
  parameter int LINES_RST = 625,
  parameter int CLAMP_DIV = 4,
  parameter int HS_W      = 8,
  parameter int VS_LINES  = 3,
  parameter int EQ_LINES  = 2,
  parameter int EQ_W      = 4,
  parameter int SC_THR    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        h_in,
  input  logic        v_in,
  output logic        h_out,
  output logic        v_out,
  output logic        sync_oe,
  output logic        disp_hstart,
  output logic        disp_vstart,
  output logic        clamp_win
);
  rsg_cfg_t          cfg;
  logic              h_ev, v_ev;
  logic [RSG_HW-1:0] hcnt;
  logic [RSG_VW-1:0] vcnt;

  rsg_regs #(
    .VDLY_RST(VDLY_RST), .HDLY_RST(HDLY_RST), .CLB_RST(CLB_RST),
    .CLE_RST(CLE_RST), .HPER_RST(HPER_RST), .LINES_RST(LINES_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg(cfg)
  );

  rsg_sync_in #(.SC_THR(SC_THR)) sync_i (
    .clk(clk), .rst_n(rst_n), .h_in(h_in), .v_in(v_in),
    .sc_sel(cfg.sc_sel), .h_ev(h_ev), .v_ev(v_ev)
  );

  rsg_counters cnt_i (
    .clk(clk), .rst_n(rst_n), .master(cfg.master), .hper(cfg.hper),
    .lines(cfg.lines), .h_ev(h_ev), .v_ev(v_ev), .hcnt(hcnt), .vcnt(vcnt)
  );

  rsg_decode #(
    .CLAMP_DIV(CLAMP_DIV), .HS_W(HS_W), .VS_LINES(VS_LINES),
    .EQ_LINES(EQ_LINES), .EQ_W(EQ_W)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .master(cfg.master), .comp(cfg.comp),
    .hcnt(hcnt), .vcnt(vcnt), .hper(cfg.hper), .lines(cfg.lines),
    .hdelay(cfg.hdelay), .vdelay(cfg.vdelay),
    .clamp_b(cfg.clamp_b), .clamp_e(cfg.clamp_e),
    .h_out(h_out), .v_out(v_out), .sync_oe(sync_oe),
    .disp_hstart(disp_hstart), .disp_vstart(disp_vstart),
    .clamp_win(clamp_win)
  );
endmodule

// File: tb/raster_sync_gen_tb_top.sv
`timescale 1ns/1ps
module raster_sync_gen_tb_top;
  localparam int HS_W = 8, VS_LINES = 3, EQ_LINES = 2, EQ_W = 4;
  localparam int SC_THR = 16, CLAMP_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic        h_in = 1'b0, v_in = 1'b0;
  logic [15:0] rd_data;
  logic        h_out, v_out, sync_oe, disp_hstart, disp_vstart, clamp_win;

  always #4 clk = ~clk;

  raster_sync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .h_in(h_in), .v_in(v_in), .h_out(h_out), .v_out(v_out),
    .sync_oe(sync_oe), .disp_hstart(disp_hstart),
    .disp_vstart(disp_vstart), .clamp_win(clamp_win)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0;
  string phase = "R1";

  // behavioural reference state
  int m_h, m_v, m_scw;
  bit m_hq, m_vq;
  int r_master, r_sc, r_comp, r_vd, r_hd, r_cb, r_ce, r_hp, r_ln;

  task automatic m_reset();
    m_h = 0; m_v = 0; m_scw = 0; m_hq = 0; m_vq = 0;
    r_master = 0; r_sc = 0; r_comp = 0; r_vd = 32; r_hd = 72;
    r_cb = 2; r_ce = 10; r_hp = 1024; r_ln = 625;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit hev, vev, fall;
      int hl, vl;
      if (r_sc != 0) begin
        fall = m_hq && !h_in;
        vev  = fall && (m_scw >= SC_THR);
        hev  = fall && !vev;
      end else begin
        hev = h_in && !m_hq;
        vev = v_in && !m_vq;
      end
      hl = (r_hp == 0) ? 0 : r_hp - 1;
      vl = (r_ln == 0) ? 0 : r_ln - 1;
      if (r_master != 0) begin
        if (m_h >= hl) begin
          m_h = 0;
          m_v = (m_v >= vl) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end else if (vev) begin
        m_h = 0; m_v = 0;
      end else if (hev) begin
        m_h = 0;
        if (m_v < 1023) m_v = m_v + 1;
      end else if (m_h < 4095) m_h = m_h + 1;
      m_scw = h_in ? ((m_scw >= SC_THR) ? SC_THR : m_scw + 1) : 0;
      m_hq = h_in; m_vq = v_in;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin r_master = wr_data[0]; r_sc = wr_data[1]; r_comp = wr_data[2]; end
          3'd1: r_vd = wr_data & 16'h03FF;
          3'd2: r_hd = wr_data & 16'h0FFF;
          3'd3: r_cb = wr_data & 16'h00FF;
          3'd4: r_ce = wr_data & 16'h00FF;
          3'd5: r_hp = wr_data & 16'h0FFF;
          3'd6: r_ln = wr_data & 16'h03FF;
          default: ;
        endcase
      end
    end
  end

  function automatic int e_hs(); return (r_master != 0 && m_h < HS_W) ? 1 : 0; endfunction

  function automatic int e_vout();
    int half; bit vs, eq, ep;
    if (r_master == 0) return 0;
    vs = m_v < VS_LINES;
    if (r_comp == 0) return vs ? 1 : 0;
    half = r_hp / 2;
    eq = !vs && ((m_v < VS_LINES + EQ_LINES) || (m_v + EQ_LINES >= r_ln));
    ep = (m_h < EQ_W) || (m_h >= half && m_h < half + EQ_W);
    if (vs) return 1;
    if (eq) return ep ? 1 : 0;
    return (m_h < HS_W) ? 1 : 0;
  endfunction

  function automatic int e_clamp();
    int b, e;
    b = r_cb * CLAMP_DIV; e = r_ce * CLAMP_DIV;
    if (r_cb <= r_ce) return (m_h >= b && m_h < e) ? 1 : 0;
    return (m_h >= b || m_h < e) ? 1 : 0;
  endfunction

  function automatic int e_rd(int a);
    case (a)
      0: return r_master | (r_sc << 1) | (r_comp << 2);
      1: return r_vd;  2: return r_hd;  3: return r_cb;
      4: return r_ce;  5: return r_hp;  6: return r_ln;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL [%s] %s: actual %0d expected %0d at %0t", phase, nm, act, exp, $time);
    end
  endtask

  // compare every cycle at the falling edge, far from input changes
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("h_out (R6)", int'(h_out), e_hs());
      chk("v_out (R6 R7)", int'(v_out), e_vout());
      chk("sync_oe (R6)", int'(sync_oe), r_master);
      chk("disp_hstart (R9)", int'(disp_hstart), (m_h == r_hd) ? 1 : 0);
      chk("disp_vstart (R9)", int'(disp_vstart), (m_h == 0 && m_v == r_vd) ? 1 : 0);
      chk("clamp_win (R10 R11)", int'(clamp_win), e_clamp());
      chk("rd_data (R1 R2)", int'(rd_data), e_rd(int'(rd_addr)));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic line_sep(int hi, int len, int vpos);
    for (int i = 0; i < len; i++) begin
      h_in = (i < hi);
      v_in = (vpos >= 0 && i >= vpos && i < vpos + 2);
      rd_addr = 3'(i % 8);
      cyc(1);
    end
  endtask

  task automatic line_sc(int hi, int len);
    for (int i = 0; i < len; i++) begin
      h_in = (i < hi);
      v_in = ((i % 3) == 0);   // R4: ignored in sandcastle mode
      cyc(1);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    cmp_en = 1;
    phase = "R1";
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); cyc(1); end

    phase = "R2";
    wr(1, 16'hFFFF); rd_addr = 3'd1; cyc(1);
    wr(2, 16'hFABC); rd_addr = 3'd2; cyc(1);
    wr(3, 16'h1F01); rd_addr = 3'd3; cyc(1);
    wr(0, 16'hFFF8); rd_addr = 3'd0; cyc(1);
    wr(7, 16'h1234); rd_addr = 3'd7; cyc(1);
    wr(1, 2); wr(2, 5); wr(3, 1); wr(4, 3); wr(5, 60); wr(6, 12);
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); cyc(1); end

    phase = "R3 R9 R10";
    for (int l = 0; l < 8; l++) line_sep(3, 40, (l == 2) ? 17 : -1);
    line_sep(0, 30, -1);

    phase = "R11";
    wr(3, 3); wr(4, 1);
    for (int l = 0; l < 4; l++) line_sep(2, 40, (l == 1) ? 25 : -1);

    phase = "R4";
    wr(3, 1); wr(4, 3);
    wr(0, 2);
    for (int l = 0; l < 10; l++) line_sc((l == 4) ? 20 : ((l == 7) ? 16 : ((l == 8) ? 15 : 4)), 50);

    phase = "R8";
    wr(0, 0);
    line_sep(3, 20, -1);
    wr(0, 1);
    cyc(120);

    phase = "R5 R6";
    wr(5, 44); wr(6, 9);
    for (int i = 0; i < 900; i++) begin h_in = i[3]; v_in = i[5]; cyc(1); end
    h_in = 0; v_in = 0;
    wr(5, 60); wr(6, 12);

    phase = "R7";
    wr(0, 5);
    cyc(1600);
    wr(5, 51);
    cyc(1300);

    phase = "R3 R5";
    wr(0, 0);
    for (int l = 0; l < 3; l++) line_sep(3, 40, (l == 1) ? 5 : -1);

    cmp_en = 0;
    summary();
    $finish;
  end
endmodule